// File: doc/BRIEF.md
# Receive-side XON/XOFF flow-control detector

This block sits between a UART receiver and its receive FIFO. It checks every received character against four programmable flow-control codes. When it finds a stop code, it asks the transmitter to pause. When it finds a resume code, it lets the transmitter continue. Characters it recognises as flow-control codes are consumed here and never reach the FIFO. Everything else is passed on as a one-cycle FIFO write.

A stop or resume can be one character long (single mode) or a pair of consecutive characters (double mode). In double mode, a possible first character of a pair is held back until the next character shows whether the pair is complete. Only the low 5 to 8 bits, set by the word length, take part in a comparison. An optional special-character mode sets the status flag whenever the fourth code arrives, but still passes that character to the FIFO.

The halt output only gates the start of the next transmitted character, so a character already being shifted out always completes. Reception, and FIFO writes of ordinary characters, go on while transmission is halted. The receive strobe must be followed by at least two idle cycles before the next strobe, which a serial receiver always satisfies.

Top module: `xonxoff_rx_ctl`

## Requirements
- R1: Out of reset, the four code registers hold 0x00, and `tx_halt`, `fc_flag`, `irq` and `fifo_wr` are all 0.
- R2: A write with `reg_we` loads `reg_wdata` into a code register chosen by `reg_sel`: 0 = resume code 1, 1 = resume code 2, 2 = stop code 1, 3 = stop code 2.
- R3: In single mode with automatic control on, a character that matches stop code 1 sets `tx_halt` and `fc_flag` on the clock edge that samples it, and is not written to the FIFO. If a character matches both code 1 values, the stop takes priority.
- R4: In single mode, a character that matches resume code 1 clears `tx_halt` and `fc_flag`, and is not written to the FIFO.
- R5: In double mode, the sequence stop1 then stop2 halts transmission and sets the flag. The sequence resume1 then resume2 resumes transmission and clears the flag. Neither character of a completed pair is written to the FIFO.
- R6: In double mode, a held first character whose follower does not complete a pair is written to the FIFO on the edge that samples the follower. If the follower matches a first code, it is then held. Otherwise it is written on the next edge.
- R7: Comparisons use only the low 5, 6, 7 or 8 bits, for `word_len` = 0, 1, 2 or 3. Register bit 0 lines up with the character's LSB.
- R8: `irq` is high exactly when `fc_flag` is high and `xoff_ie` is 1.
- R9: With `spec_en` set, a character that matches stop code 2 sets `fc_flag` and is still written to the FIFO, unless flow control consumes it.
- R10: With `auto_en` low, every received character is written to the FIFO one edge after its strobe, and `tx_halt` never changes.
- R11: An ordinary character is written to the FIFO, with its data unchanged, on the edge that samples its strobe. This also holds while `tx_halt` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Code register write strobe |
| reg_sel | input | 2 | Code register select (0 resume1, 1 resume2, 2 stop1, 3 stop2) |
| reg_wdata | input | CW | Code register write data |
| word_len | input | 2 | Character length: 0..3 selects 5..8 bits |
| auto_en | input | 1 | Automatic flow control enable |
| dbl_mode | input | 1 | Two-character code mode |
| spec_en | input | 1 | Special-character detect enable |
| xoff_ie | input | 1 | Interrupt enable for the flow-control flag |
| rx_valid | input | 1 | Received-character strobe |
| rx_data | input | CW | Received character |
| fifo_wr | output | 1 | Receive FIFO write strobe |
| fifo_data | output | CW | Receive FIFO write data |
| tx_halt | output | 1 | Do not start a new transmit character |
| fc_flag | output | 1 | Flow-control / special-character status flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default character width of 8. With that width, all four word lengths can be reached, so the masked compare can be tested by characters that differ only in the bits above the selected length. Random characters are drawn mostly from the four programmed codes. This makes partial pairs, repeated first codes, and codes shared between the stop and resume sets likely, all under both single and double mode. A reference model in the bench predicts up to two FIFO writes per character and the halt and flag states.

// File: rtl/xonxoff_rx_ctl.sv
module xonxoff_rx_ctl #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_sel,
  input  logic [CW-1:0] reg_wdata,
  input  logic [1:0]    word_len,
  input  logic          auto_en,
  input  logic          dbl_mode,
  input  logic          spec_en,
  input  logic          xoff_ie,
  input  logic          rx_valid,
  input  logic [CW-1:0] rx_data,
  output logic          fifo_wr,
  output logic [CW-1:0] fifo_data,
  output logic          tx_halt,
  output logic          fc_flag,
  output logic          irq
);
  localparam logic [CW-1:0] FULL = {CW{1'b1}};

  logic [CW-1:0] on1, on2, off1, off2, mask, held, held_n, pend_d, w_d;
  logic          held_v, hold_n, pend_v, pend_n, w_v, xon_evt, xoff_evt;
  logic          m_on1, m_on2, m_off1, m_off2, h_on1, h_off1, spec_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      on1 <= '0; on2 <= '0; off1 <= '0; off2 <= '0;
    end else if (reg_we) begin
      case (reg_sel)
        2'd0: on1  <= reg_wdata;
        2'd1: on2  <= reg_wdata;
        2'd2: off1 <= reg_wdata;
        default: off2 <= reg_wdata;
      endcase
    end

  assign mask   = FULL >> (2'd3 - word_len);
  assign m_on1  = ((rx_data ^ on1)  & mask) == '0;
  assign m_on2  = ((rx_data ^ on2)  & mask) == '0;
  assign m_off1 = ((rx_data ^ off1) & mask) == '0;
  assign m_off2 = ((rx_data ^ off2) & mask) == '0;
  assign h_on1  = ((held ^ on1)  & mask) == '0;
  assign h_off1 = ((held ^ off1) & mask) == '0;
  assign spec_hit = rx_valid && spec_en && m_off2;
  assign irq = fc_flag && xoff_ie;

  always_comb begin
    xon_evt = 1'b0; xoff_evt = 1'b0;
    w_v = 1'b0; w_d = rx_data;
    hold_n = held_v; held_n = held; pend_n = 1'b0;
    if (rx_valid) begin
      if (!auto_en) begin
        w_v = 1'b1; hold_n = 1'b0;
      end else if (!dbl_mode) begin
        hold_n = 1'b0;
        if (m_off1)     xoff_evt = 1'b1;
        else if (m_on1) xon_evt = 1'b1;
        else            w_v = 1'b1;
      end else if (held_v) begin
        if (h_off1 && m_off2) begin
          xoff_evt = 1'b1; hold_n = 1'b0;
        end else if (h_on1 && m_on2) begin
          xon_evt = 1'b1; hold_n = 1'b0;
        end else begin
          w_v = 1'b1; w_d = held;
          if (m_on1 || m_off1) held_n = rx_data;
          else begin hold_n = 1'b0; pend_n = 1'b1; end
        end
      end else if (m_on1 || m_off1) begin
        hold_n = 1'b1; held_n = rx_data;
      end else begin
        w_v = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      held_v <= 1'b0; held <= '0; pend_v <= 1'b0; pend_d <= '0;
      fifo_wr <= 1'b0; fifo_data <= '0; tx_halt <= 1'b0; fc_flag <= 1'b0;
    end else begin
      held_v <= hold_n; held <= held_n;
      pend_v <= pend_n; pend_d <= rx_data;
      fifo_wr <= w_v || pend_v;
      fifo_data <= w_v ? w_d : pend_d;
      tx_halt <= xoff_evt ? 1'b1 : (xon_evt ? 1'b0 : tx_halt);
      fc_flag <= (fc_flag && !xon_evt) || xoff_evt || spec_hit;
    end

  assert_halt_needs_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_halt) |-> $past(rx_valid) && $past(auto_en));
  assert_resume_needs_rx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_halt) |-> $past(rx_valid) && $past(auto_en));
  assert_write_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> $past(rx_valid) || $past(fifo_wr));
  assert_passthru_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !auto_en && !pend_v) |=> fifo_wr && fifo_data == $past(rx_data));
  assert_flag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fc_flag) |-> $past(rx_valid) && $past(auto_en));
  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> fc_flag);
endmodule

// File: tb/xonxoff_rx_ctl_tb.sv
module xonxoff_rx_ctl_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 0, auto_en = 0, dbl_mode = 0, spec_en = 0, xoff_ie = 0, rx_valid = 0;
  logic [1:0] reg_sel = 0, word_len = 2'd3;
  logic [7:0] reg_wdata = 0, rx_data = 0;
  logic fifo_wr, tx_halt, fc_flag, irq;
  logic [7:0] fifo_data;
  int n_chk = 0, n_bad = 0;

  logic [7:0] c_on1, c_on2, c_off1, c_off2, m_hd;
  logic m_halt, m_flag, m_hv;

  xonxoff_rx_ctl u_dut (.*);

  always #5 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act=timeout exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic same(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] mk;
    mk = (word_len == 0) ? 8'h1F : (word_len == 1) ? 8'h3F : (word_len == 2) ? 8'h7F : 8'hFF;
    return ((a & mk) == (b & mk));
  endfunction

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_we = 0;
    case (s) 0: c_on1 = d; 1: c_on2 = d; 2: c_off1 = d; default: c_off2 = d; endcase
  endtask

  // send one character, predict, check both possible write slots
  task automatic send(input logic [7:0] c, input string req);
    logic e0v, e1v, xon, xoff; logic [7:0] e0d, e1d;
    e0v = 0; e1v = 0; e0d = c; e1d = c; xon = 0; xoff = 0;
    if (!auto_en) begin e0v = 1; m_hv = 0; end
    else if (!dbl_mode) begin
      m_hv = 0;
      if (same(c, c_off1)) xoff = 1; else if (same(c, c_on1)) xon = 1; else e0v = 1;
    end else if (m_hv) begin
      if (same(m_hd, c_off1) && same(c, c_off2)) begin xoff = 1; m_hv = 0; end
      else if (same(m_hd, c_on1) && same(c, c_on2)) begin xon = 1; m_hv = 0; end
      else begin
        e0v = 1; e0d = m_hd;
        if (same(c, c_on1) || same(c, c_off1)) m_hd = c;
        else begin m_hv = 0; e1v = 1; end
      end
    end else if (same(c, c_on1) || same(c, c_off1)) begin m_hv = 1; m_hd = c; end
    else e0v = 1;
    if (xoff) m_halt = 1; else if (xon) m_halt = 0;
    m_flag = (m_flag && !xon) || xoff || (spec_en && same(c, c_off2));
    @(negedge clk); rx_valid = 1; rx_data = c;
    @(negedge clk); rx_valid = 0;
    chk({req, " wr0"}, fifo_wr, e0v);
    if (e0v) chk({req, " data0"}, fifo_data, e0d);
    chk({req, " halt"}, tx_halt, m_halt);
    chk({req, " flag"}, fc_flag, m_flag);
    chk({req, " irq R8"}, irq, m_flag && xoff_ie);
    @(negedge clk);
    chk({req, " wr1"}, fifo_wr, e1v);
    if (e1v) chk({req, " data1"}, fifo_data, e1d);
  endtask

  initial begin
    void'($urandom(32'd1234));
    c_on1 = 0; c_on2 = 0; c_off1 = 0; c_off2 = 0; m_halt = 0; m_flag = 0; m_hv = 0; m_hd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 halt", tx_halt, 0); chk("R1 flag", fc_flag, 0);
    chk("R1 irq", irq, 0); chk("R1 wr", fifo_wr, 0);
    auto_en = 1;
    send(8'h00, "R1 zero codes stop");
    send(8'h41, "R11 normal while halted");
    wr_reg(0, 8'h11); wr_reg(1, 8'h12); wr_reg(2, 8'h13); wr_reg(3, 8'h14);
    send(8'h11, "R2 R4 resume1");
    xoff_ie = 1;
    send(8'h13, "R3 stop1");
    send(8'h55, "R11 rx while halted");
    send(8'h11, "R4 resume");
    word_len = 0;
    send(8'hF3, "R7 5-bit stop");
    send(8'hB1, "R7 5-bit resume");
    word_len = 3;
    send(8'hF3, "R7 8-bit no match");
    dbl_mode = 1;
    send(8'h13, "R5 hold stop1"); send(8'h14, "R5 stop pair");
    send(8'h11, "R5 hold resume1"); send(8'h12, "R5 resume pair");
    send(8'h13, "R6 hold"); send(8'h13, "R6 rehold"); send(8'h77, "R6 flush both");
    send(8'h11, "R6 hold"); send(8'h14, "R6 broken");
    dbl_mode = 0; spec_en = 1;
    send(8'h14, "R9 special");
    send(8'h11, "R9 clear");
    auto_en = 0;
    send(8'h13, "R10 passthru stop");
    send(8'h11, "R10 passthru resume");
    auto_en = 1;
    for (int i = 0; i < 400; i++) begin
      logic [7:0] c;
      case ($urandom % 6)
        0: c = c_on1; 1: c = c_on2; 2: c = c_off1; 3: c = c_off2;
        default: c = 8'($urandom);
      endcase
      if (!m_hv && ($urandom % 16 == 0)) begin
        dbl_mode = 1'($urandom); spec_en = 1'($urandom); xoff_ie = 1'($urandom);
        word_len = 2'($urandom);
      end
      send(c, "R5 R6 R7 R9 random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule